// File: doc/BRIEF.md
# DMA-Gated Field Data Writer

This block takes a stream of words captured from field I/O ports and writes them into a shared single-port SRAM. No word goes to the SRAM directly. Every accepted word first lands in an internal FIFO, and the FIFO drains one word per cycle into consecutive SRAM addresses. Draining happens only while neither of two DMA channels is reading that SRAM.

Each DMA channel reports a transfer in progress by holding its acknowledge input low. Both acknowledges are resynchronised. While either one is low, the block stops issuing SRAM writes and keeps accepting field words into the FIFO. When both return high, the block waits one turnaround cycle and then resumes draining. This way the DMA reads are never delayed and incoming samples are not lost, up to the FIFO's capacity.

The next SRAM address to be written is exposed so that software can track how far the buffer has filled. A sticky flag records any word that was dropped because it arrived while the FIFO was full.

Top module: `dma_gated_writer`

## Requirements
- R1: While reset is held and on the first cycle after it, `sram_we`, `sram_ce` and `ovf_flag` are 0 and `wr_level` is 0.
- R2: Every accepted field word is written to the SRAM exactly once, in arrival order, and only after it has passed through the FIFO. A word is written no earlier than the second clock edge after it is presented.
- R3: Each acknowledge passes through two flip-flops, and the SRAM counts as busy when either synchronised acknowledge is low. A write whose decision was taken before busy was seen may still appear. From the cycle after busy is seen, `sram_we` stays 0 for as long as busy lasts.
- R4: After busy goes away, there is one cycle with no write before the first drain write. With an acknowledge released before clock edge E0 and words waiting in the FIFO, `sram_we` is 0 after E2 and 1 after E3.
- R5: Field words offered while a DMA transfer is in progress are accepted into the FIFO, and `wr_level` does not move until the transfer ends.
- R6: `wr_level` is the next SRAM address. It starts at 0, advances by one per write and wraps from SRAM_DEPTH-1 to 0. Each write uses the value `wr_level` had before that write.
- R7: A word presented while the FIFO holds FIFO_DEPTH words is discarded, and `ovf_flag` is 1 from the following cycle. Fullness is judged on the occupancy before any drain in the same cycle.
- R8: `ovf_flag` stays set until `ovf_clr` is high at a clock edge. If a word is discarded in that same cycle, the flag stays set.
- R9: `sram_ce` is high exactly in the cycles in which `sram_we` is high.
- R10: While the gate is open and the FIFO is not empty, one word is written on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fd_valid | input | 1 | Field word present this cycle |
| fd_data | input | DATA_W | Field word |
| dack0_n | input | 1 | Channel 0 DMA transfer in progress, active low, asynchronous |
| dack1_n | input | 1 | Channel 1 DMA transfer in progress, active low, asynchronous |
| ovf_clr | input | 1 | Clears the overflow flag |
| sram_ce | output | 1 | SRAM chip enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | log2(SRAM_DEPTH) | SRAM write address |
| sram_wdata | output | DATA_W | SRAM write data |
| wr_level | output | log2(SRAM_DEPTH) | Next SRAM address to be written |
| ovf_flag | output | 1 | Sticky flag for a dropped field word |

## Verification
The properties assume that both acknowledges settle to known levels before reset is released. They also assume that `fd_valid` and `ovf_clr` change only away from the active clock edge. The bench meets both conditions by driving every input on the falling edge. It lowers the acknowledges for runs of many cycles, so every busy window covers the two synchroniser stages and the in-flight write that R3 allows. The overflow property relies on the FIFO being held full by a DMA window. The stimulus arranges this by holding one acknowledge low while it offers more words than the FIFO holds.

// File: rtl/gdw_pkg.sv
package gdw_pkg;

    // Number of DMA channels that can claim the SRAM.
    localparam int NUM_DMA = 2;

    // Drain gate: closed while busy and for one cycle after it.
    typedef enum logic {
        GATE_HOLD = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

endpackage

// File: rtl/gdw_ack_sync.sv
module gdw_ack_sync #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ack_n_raw,
    output logic           busy
);

    typedef struct packed {
        logic [NCH-1:0] s1;
        logic [NCH-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ack_n_raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1};
        end else begin
            st_q <= st_d;
        end
    end

    // Any synchronised acknowledge low marks the memory as taken.
    assign busy = ~&st_q.s2;

endmodule

// File: rtl/gdw_fifo.sv
module gdw_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          clr,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full,
    output logic          ovf
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rd_data = mem[st_q.rd];
    assign ovf     = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wr = step_ptr(st_q.wr);
        if (pop_ok)  st_d.rd = step_ptr(st_q.rd);
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        if (push && full) begin
            st_d.ovf = 1'b1;
        end else if (clr) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Storage carries no reset; occupancy is tracked by the counter.
    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= push_data;
    end

endmodule

// File: rtl/gdw_drain.sv
module gdw_drain
    import gdw_pkg::*;
#(
    parameter int DW = 32,
    parameter int SD = 1024,
    localparam int AW = (SD > 1) ? $clog2(SD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          pop,
    output logic          sram_ce,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    output logic [AW-1:0] wr_level
);

    typedef struct packed {
        gate_e         gate;
        logic          we;
        logic          ce;
        logic [AW-1:0] addr;
        logic [AW-1:0] lvl;
        logic [DW-1:0] wdata;
    } drain_st_t;

    drain_st_t st_d, st_q;

    // A write is committed only if the gate was already open last cycle.
    assign pop = !busy && (st_q.gate == GATE_OPEN) && !fifo_empty;

    always_comb begin
        st_d      = st_q;
        st_d.gate = busy ? GATE_HOLD : GATE_OPEN;
        st_d.we   = pop;
        st_d.ce   = pop;
        if (pop) begin
            st_d.addr  = st_q.lvl;
            st_d.wdata = fifo_data;
            st_d.lvl   = (st_q.lvl == AW'(SD - 1)) ? '0 : st_q.lvl + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{gate: GATE_HOLD, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sram_ce    = st_q.ce;
    assign sram_we    = st_q.we;
    assign sram_addr  = st_q.addr;
    assign sram_wdata = st_q.wdata;
    assign wr_level   = st_q.lvl;

endmodule

// File: rtl/dma_gated_writer.sv
module dma_gated_writer
    import gdw_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FIFO_DEPTH  = 512,
    parameter int SRAM_DEPTH  = 1024,
    localparam int AW = (SRAM_DEPTH > 1) ? $clog2(SRAM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fd_valid,
    input  logic [DATA_W-1:0] fd_data,
    input  logic              dack0_n,
    input  logic              dack1_n,
    input  logic              ovf_clr,
    output logic              sram_ce,
    output logic              sram_we,
    output logic [AW-1:0]     sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic [AW-1:0]     wr_level,
    output logic              ovf_flag
);

    logic              busy_s;
    logic              pop;
    logic              fifo_empty;
    logic              fifo_full;
    logic [DATA_W-1:0] fifo_data;

    gdw_ack_sync #(.NCH(NUM_DMA)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n_raw ({dack1_n, dack0_n}),
        .busy      (busy_s)
    );

    gdw_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fd_valid),
        .push_data (fd_data),
        .pop       (pop),
        .clr       (ovf_clr),
        .rd_data   (fifo_data),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .ovf       (ovf_flag)
    );

    gdw_drain #(.DW(DATA_W), .SD(SRAM_DEPTH)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy_s),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (pop),
        .sram_ce    (sram_ce),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .wr_level   (wr_level)
    );

endmodule

// File: rtl/gdw_checker.sv
module gdw_checker #(
    parameter int SD = 1024,
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          fifo_empty,
    input logic          fifo_full,
    input logic          fd_valid,
    input logic          ovf_clr,
    input logic          ovf_flag,
    input logic          sram_we,
    input logic [AW-1:0] sram_addr,
    input logic [AW-1:0] wr_level
);

    localparam logic [AW-1:0] LAST = AW'(SD - 1);

    p_halt_on_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !sram_we);

    p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !sram_we);

    p_write_from_fifo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> !$past(fifo_empty));

    p_level_follows_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (wr_level == ((sram_addr == LAST) ? '0 : sram_addr + AW'(1))));

    p_drop_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_valid && fifo_full) |=> ovf_flag);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind dma_gated_writer gdw_checker #(.SD(SRAM_DEPTH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy_s),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fd_valid   (fd_valid),
    .ovf_clr    (ovf_clr),
    .ovf_flag   (ovf_flag),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .wr_level   (wr_level)
);

// File: tb/dma_gated_writer_bench.sv
module dma_gated_writer_bench;

    localparam int DW = 32;
    localparam int FD = 512;
    localparam int SD = 1024;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fd_valid = 1'b0;
    logic [DW-1:0] fd_data = '0;
    logic          dack0_n = 1'b1;
    logic          dack1_n = 1'b1;
    logic          ovf_clr = 1'b0;
    logic          sram_ce, sram_we, ovf_flag;
    logic [AW-1:0] sram_addr, wr_level;
    logic [DW-1:0] sram_wdata;

    always #2 clk = ~clk;

    dma_gated_writer #(.DATA_W(DW), .FIFO_DEPTH(FD), .SRAM_DEPTH(SD)) u_dma_gated_writer (
        .clk(clk), .rst_n(rst_n), .fd_valid(fd_valid), .fd_data(fd_data),
        .dack0_n(dack0_n), .dack1_n(dack1_n), .ovf_clr(ovf_clr),
        .sram_ce(sram_ce), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .wr_level(wr_level), .ovf_flag(ovf_flag)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: queue for the FIFO, plain bits for the timing.
    logic [DW-1:0] mq[$];
    logic [DW-1:0] ref_mem[int];
    bit            ms1[2], ms2[2];
    bit            m_open, e_we, e_ovf;
    logic [DW-1:0] e_data;
    int            e_addr, e_ptr, n_acc;

    always @(posedge clk) begin
        bit busy, pop, full;
        if (!rst_n) begin
            mq.delete();
            ms1[0] = 1; ms1[1] = 1; ms2[0] = 1; ms2[1] = 1;
            m_open = 0; e_we = 0; e_ovf = 0; e_addr = 0; e_ptr = 0;
        end else begin
            busy = !(ms2[0] && ms2[1]);
            pop  = (mq.size() > 0) && !busy && m_open;
            full = (mq.size() == FD);
            m_open = !busy;
            ms2[0] = ms1[0]; ms2[1] = ms1[1];
            ms1[0] = dack0_n; ms1[1] = dack1_n;
            e_we = pop;
            if (pop) begin
                e_data = mq.pop_front();
                e_addr = e_ptr;
                ref_mem[e_ptr] = e_data;
                e_ptr = (e_ptr + 1) % SD;
            end
            if (fd_valid && !full) begin
                mq.push_back(fd_data);
                n_acc++;
            end
            if (fd_valid && full) e_ovf = 1;
            else if (ovf_clr) e_ovf = 0;
        end
    end

    // Behavioural SRAM.
    logic [DW-1:0] sram [SD];
    int n_wr = 0;
    always @(posedge clk) begin
        if (rst_n && sram_ce && sram_we) begin
            sram[sram_addr] <= sram_wdata;
            n_wr++;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", "we", sram_we, e_we);
            check("R9", "ce", sram_ce, e_we);
            check("R7", "ovf", ovf_flag, e_ovf);
            check("R6", "level", wr_level, e_ptr);
            if (e_we) begin
                check("R6", "addr", sram_addr, e_addr);
                check("R2", "data", sram_wdata, e_data);
            end
        end
    end

    task automatic step(input bit v);
        fd_valid = v;
        if (v) fd_data = $urandom;
        @(negedge clk);
    endtask

    initial begin
        int lvl_hold;
        repeat (4) @(negedge clk);
        check("R1", "we in reset", sram_we, 0);
        check("R1", "ce in reset", sram_ce, 0);
        check("R1", "level in reset", wr_level, 0);
        check("R1", "ovf in reset", ovf_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "we after reset", sram_we, 0);
        check("R1", "level after reset", wr_level, 0);

        // Free-running stream, gate open.
        for (int i = 0; i < 40; i++) step(1);

        // Channel 0 claims the memory while data keeps arriving.
        dack0_n = 1'b0;
        step(1); step(1); step(1);
        for (int i = 0; i < 8; i++) begin
            check("R3", "no write while busy", sram_we, 0);
            step(1);
        end
        lvl_hold = wr_level;
        for (int i = 0; i < 30; i++) step(i % 2 == 0);
        check("R5", "level frozen during DMA", wr_level, lvl_hold);

        // Release: one bubble, then back-to-back writes.
        dack0_n = 1'b1;
        step(0); step(0); step(0);
        check("R4", "idle turnaround cycle", sram_we, 0);
        step(0);
        check("R4", "first drain write", sram_we, 1);
        for (int i = 0; i < 4; i++) begin
            step(0);
            check("R10", "one write per cycle", sram_we, 1);
        end
        for (int i = 0; i < 40; i++) step(0);

        // Overflow while channel 1 holds the memory.
        dack1_n = 1'b0;
        for (int i = 0; i < 4; i++) step(0);
        lvl_hold = wr_level;
        for (int i = 0; i < FD + 10; i++) step(1);
        step(0);
        check("R7", "flag after drop", ovf_flag, 1);
        check("R5", "level frozen while filling", wr_level, lvl_hold);
        ovf_clr = 1'b1; step(0); ovf_clr = 1'b0;
        check("R8", "clear", ovf_flag, 0);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        check("R8", "drop beats clear", ovf_flag, 1);
        ovf_clr = 1'b1; step(0); ovf_clr = 1'b0;
        check("R8", "clear again", ovf_flag, 0);

        dack1_n = 1'b1;
        for (int i = 0; i < FD + 20; i++) step(0);
        check("R5", "all accepted words written", n_wr, n_acc);

        // Random traffic on both channels.
        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(0, 19) == 0) dack0_n = ~dack0_n;
            if ($urandom_range(0, 29) == 0) dack1_n = ~dack1_n;
            step($urandom_range(0, 9) < 7);
        end
        dack0_n = 1'b1; dack1_n = 1'b1;
        for (int i = 0; i < FD + 20; i++) step(0);
        check("R5", "writes equal accepted words", n_wr, n_acc);
        check("R6", "wrapped level", wr_level, n_acc % SD);
        check("R6", "wrap exercised", (n_acc >= SD) ? 1 : 0, 1);

        foreach (ref_mem[k]) check("R2", "sram contents", sram[k], ref_mem[k]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule